// File: doc/BRIEF.md
# Programmable Parallel Port Register Interface

This block is the processor-facing register front end of a three-port parallel I/O controller. A 2-bit address, an active-low chip select and active-low read and write strobes give the host access to two 8-bit port output latches (A and B), a split 8-bit port C latch, and a control register. The port pins, the handshake sequencing and the electrical pin behaviour live in neighbouring logic. This block supplies that logic with the mode and direction settings, the three interrupt-enable flags and a pulse that clears its status flags.

A single control address carries two kinds of command, chosen by data bit 7. One kind defines the modes and directions of both port groups. The other kind forces a single port C bit high or low. When a group runs a handshake mode, that command instead reaches the interrupt-enable flag that shares the bit's position. A direct write to port C is masked, so handshake lines and input lines cannot be disturbed.

All strobes are sampled by the system clock. A write takes effect on the clock edge where the synchronised write strobe is first seen low.

Top module: `pio_cpu_if`

## Requirements
- R1: Reads are combinational while `cs_n` and `rd_n` are both low, and `dout_valid` is then high. The address selects the source: 00 is port A, 01 is port B, 10 is port C and 11 is the control register. For port A or port B, the read returns the pins when that port's direction is input and the latch when it is output. For port C, each nibble follows its own direction bit in the same way.
- R2: A write takes effect once for each falling edge of `wr_n`, and only if `cs_n` is low at the commit edge. A write strobe with `cs_n` high changes nothing.
- R3: A control write with bit 7 = 1 loads the mode word. Bits 6:5 give the group A mode (00 = mode 0, 01 = mode 1, 1x = mode 2, reported as 2 on `grp_a_mode`). Bit 4 set makes port A an input. Bit 3 set makes port C upper an input. Bit 2 gives the group B mode (0 or 1). Bit 1 set makes port B an input. Bit 0 set makes port C lower an input.
- R4: A read of the control address returns the stored mode word with bit 7 forced to 1.
- R5: Reset sets both groups to mode 0 with every port an input, so the control read returns 8'h9B. Reset also clears every latch and every interrupt-enable flag.
- R6: A mode-word write clears the A, B and C latches and the three interrupt-enable flags, and pulses `flags_clr` for one cycle.
- R7: Writes to address 00 or 01 load the port A or port B latch in full, whatever the direction setting.
- R8: A control write with bit 7 = 0 selects port C bit n with bits 3:1 and takes its new value from bit 0. Bits 6:4 are ignored. The selected latch bit changes only if its nibble is an output.
- R9: When that set/reset command targets a port C bit whose nibble is an input, and the bit is not an interrupt-enable position, the port C latch is left unchanged.
- R10: While group A is in mode 1 or 2, a set/reset at bit 6 writes `inte_a_out` and a set/reset at bit 4 writes `inte_a_in`. While group B is in mode 1, a set/reset at bit 2 writes `inte_b`. In these three cases the port C latch is unchanged.
- R11: A direct write to port C changes only the bits of a nibble that is an output and whose owning group is in mode 0. The lower nibble belongs to group B and the upper nibble to group A. The write never changes an interrupt-enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_valid | output | 1 | High while a read is in progress |
| pa_in | input | 8 | Port A pin values |
| pb_in | input | 8 | Port B pin values |
| pc_in | input | 8 | Port C pin values |
| pa_latch | output | 8 | Port A output latch |
| pb_latch | output | 8 | Port B output latch |
| pc_latch | output | 8 | Port C output latch |
| pa_dir_in | output | 1 | Port A is an input |
| pb_dir_in | output | 1 | Port B is an input |
| pcl_dir_in | output | 1 | Port C lower nibble is an input |
| pcu_dir_in | output | 1 | Port C upper nibble is an input |
| grp_a_mode | output | 2 | Group A mode: 0, 1 or 2 |
| grp_b_mode | output | 1 | Group B mode: 0 or 1 |
| inte_a_out | output | 1 | Group A output-side interrupt enable |
| inte_a_in | output | 1 | Group A input-side interrupt enable |
| inte_b | output | 1 | Group B interrupt enable |
| flags_clr | output | 1 | One-cycle pulse on each mode-word write |

## Verification
The assertions assume that `cs_n`, `addr` and `din` stay steady for the whole time `wr_n` is low and for a few cycles after it rises. They also assume that read and write are never low together. The bench drives each bus cycle through tasks that hold the address and data for the full strobe, keep `wr_n` low for four clocks, and release chip select three clocks after the strobe. Each read is a separate strobe made while no write is in flight. Random traffic spreads over all four addresses, mixes mode words with set/reset commands, and changes the pin values between transfers.

// File: rtl/pio_pkg.sv
package pio_pkg;

  // Mode word fields, in the bit order of control data bits 6..0
  typedef struct packed {
    logic [1:0] a_mode_raw;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } mode_cfg_t;

  typedef enum logic [2:0] {
    ROUTE_NONE,
    ROUTE_LATCH,
    ROUTE_INTE_A1,
    ROUTE_INTE_A2,
    ROUTE_INTE_B
  } bsr_route_e;

  localparam mode_cfg_t CFG_RESET = '{a_mode_raw: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                      b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  localparam logic [1:0] ADDR_PA  = 2'b00;
  localparam logic [1:0] ADDR_PB  = 2'b01;
  localparam logic [1:0] ADDR_PC  = 2'b10;
  localparam logic [1:0] ADDR_CTL = 2'b11;

  function automatic logic grp_a_handshake(mode_cfg_t c);
    return c.a_mode_raw != 2'b00;
  endfunction

  function automatic logic [1:0] grp_a_mode_code(mode_cfg_t c);
    return c.a_mode_raw[1] ? 2'd2 : {1'b0, c.a_mode_raw[0]};
  endfunction

  // Port C bits that a direct port C write may change
  function automatic logic [7:0] pc_direct_mask(mode_cfg_t c);
    logic lo_ok;
    logic hi_ok;
    lo_ok = !c.b_mode && !c.cl_in;
    hi_ok = !grp_a_handshake(c) && !c.cu_in;
    return {{4{hi_ok}}, {4{lo_ok}}};
  endfunction

  // Where a single-bit command on port C bit sel lands
  function automatic bsr_route_e bsr_route(mode_cfg_t c, logic [2:0] sel);
    logic nib_out;
    nib_out = sel[2] ? !c.cu_in : !c.cl_in;
    if (grp_a_handshake(c) && sel == 3'd6)      return ROUTE_INTE_A1;
    else if (grp_a_handshake(c) && sel == 3'd4) return ROUTE_INTE_A2;
    else if (c.b_mode && sel == 3'd2)           return ROUTE_INTE_B;
    else if (nib_out)                           return ROUTE_LATCH;
    else                                        return ROUTE_NONE;
  endfunction

endpackage

// File: rtl/pio_strobe_sync.sv
module pio_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], strobe_n};
  end

  assign fall = chain[STAGES] & ~chain[STAGES-1];

  // R2: one commit per strobe edge
  a_r2_single_commit: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/pio_mode_ctrl.sv
module pio_mode_ctrl
  import pio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr,
  input  logic [6:0] mode_data,
  input  logic       bsr_wr,
  input  bsr_route_e route,
  input  logic       bsr_val,
  input  logic       pc_wr,
  output mode_cfg_t  cfg,
  output logic [2:0] inte
);
  // inte = {a1 (output side), a2 (input side), b}
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg  <= CFG_RESET;
      inte <= '0;
    end else if (mode_wr) begin
      cfg  <= mode_cfg_t'(mode_data);
      inte <= '0;
    end else if (bsr_wr) begin
      case (route)
        ROUTE_INTE_A1: inte[2] <= bsr_val;
        ROUTE_INTE_A2: inte[1] <= bsr_val;
        ROUTE_INTE_B:  inte[0] <= bsr_val;
        default: ;
      endcase
    end
  end

  a_r5_reset_cfg: assert property (@(posedge clk)
    rst |=> (cfg == CFG_RESET && inte == 3'b000));
  a_r6_inte_cleared: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> inte == 3'b000);
  a_r11_pc_write_keeps_inte: assert property (@(posedge clk) disable iff (rst)
    pc_wr |=> $stable(inte));
endmodule

// File: rtl/pio_port_latches.sv
module pio_port_latches #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_wr,
  input  logic         pa_wr,
  input  logic         pb_wr,
  input  logic         pc_wr,
  input  logic [W-1:0] pc_mask,
  input  logic         bit_wr,
  input  logic [$clog2(W)-1:0] bit_sel,
  input  logic         bit_val,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pa_q,
  output logic [W-1:0] pb_q,
  output logic [W-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (rst || mode_wr) begin
      pa_q <= '0;
      pb_q <= '0;
      pc_q <= '0;
    end else begin
      if (pa_wr) pa_q <= wdata;
      if (pb_wr) pb_q <= wdata;
      if (pc_wr) pc_q <= (pc_q & ~pc_mask) | (wdata & pc_mask);
      else if (bit_wr) pc_q[bit_sel] <= bit_val;
    end
  end

  a_r6_latches_cleared: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (pa_q == '0 && pb_q == '0 && pc_q == '0));
endmodule

// File: rtl/pio_cpu_if.sv
module pio_cpu_if
  import pio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_valid,
  input  logic [7:0] pa_in,
  input  logic [7:0] pb_in,
  input  logic [7:0] pc_in,
  output logic [7:0] pa_latch,
  output logic [7:0] pb_latch,
  output logic [7:0] pc_latch,
  output logic       pa_dir_in,
  output logic       pb_dir_in,
  output logic       pcl_dir_in,
  output logic       pcu_dir_in,
  output logic [1:0] grp_a_mode,
  output logic       grp_b_mode,
  output logic       inte_a_out,
  output logic       inte_a_in,
  output logic       inte_b,
  output logic       flags_clr
);
  localparam int W = 8;

  logic       wr_fall, commit;
  logic       mode_wr, bsr_wr, pa_wr, pb_wr, pc_wr, bit_wr;
  mode_cfg_t  cfg;
  logic [2:0] inte;
  bsr_route_e route;
  logic [7:0] pc_mask, pc_view;

  pio_strobe_sync #(.STAGES(SYNC_STAGES)) i_wr_sync (
    .clk(clk), .rst(rst), .strobe_n(wr_n), .fall(wr_fall)
  );

  // Write decode: named events for the assertions
  assign commit  = wr_fall && !cs_n;
  assign mode_wr = commit && addr == ADDR_CTL &&  din[7];
  assign bsr_wr  = commit && addr == ADDR_CTL && !din[7];
  assign pa_wr   = commit && addr == ADDR_PA;
  assign pb_wr   = commit && addr == ADDR_PB;
  assign pc_wr   = commit && addr == ADDR_PC;
  assign route   = bsr_route(cfg, din[3:1]);
  assign bit_wr  = bsr_wr && route == ROUTE_LATCH;
  assign pc_mask = pc_direct_mask(cfg);

  pio_mode_ctrl i_mode (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_data(din[6:0]),
    .bsr_wr(bsr_wr), .route(route), .bsr_val(din[0]), .pc_wr(pc_wr),
    .cfg(cfg), .inte(inte)
  );

  pio_port_latches #(.W(W)) i_latch (
    .clk(clk), .rst(rst), .mode_wr(mode_wr),
    .pa_wr(pa_wr), .pb_wr(pb_wr), .pc_wr(pc_wr), .pc_mask(pc_mask),
    .bit_wr(bit_wr), .bit_sel(din[3:1]), .bit_val(din[0]), .wdata(din),
    .pa_q(pa_latch), .pb_q(pb_latch), .pc_q(pc_latch)
  );

  assign pa_dir_in  = cfg.a_in;
  assign pb_dir_in  = cfg.b_in;
  assign pcl_dir_in = cfg.cl_in;
  assign pcu_dir_in = cfg.cu_in;
  assign grp_a_mode = grp_a_mode_code(cfg);
  assign grp_b_mode = cfg.b_mode;
  assign inte_a_out = inte[2];
  assign inte_a_in  = inte[1];
  assign inte_b     = inte[0];
  assign flags_clr  = mode_wr;

  // Read path
  assign dout_valid = !cs_n && !rd_n;
  assign pc_view = {cfg.cu_in ? pc_in[7:4] : pc_latch[7:4],
                    cfg.cl_in ? pc_in[3:0] : pc_latch[3:0]};

  always_comb begin
    dout = '0;
    if (dout_valid) begin
      case (addr)
        ADDR_PA: dout = cfg.a_in ? pa_in : pa_latch;
        ADDR_PB: dout = cfg.b_in ? pb_in : pb_latch;
        ADDR_PC: dout = pc_view;
        default: dout = {1'b1, cfg};
      endcase
    end
  end

  a_r4_ctrl_read_bit7: assert property (@(posedge clk) disable iff (rst)
    (dout_valid && addr == ADDR_CTL) |-> dout[7]);
  a_r9_bsr_input_line_kept: assert property (@(posedge clk) disable iff (rst)
    (bsr_wr && route == ROUTE_NONE) |=> $stable(pc_latch));
  a_r10_bsr_inte_latch_kept: assert property (@(posedge clk) disable iff (rst)
    (bsr_wr && route != ROUTE_LATCH && route != ROUTE_NONE) |=> $stable(pc_latch));
  a_r2_no_write_without_select: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable(pa_latch) && $stable(pb_latch) && !flags_clr));
endmodule

// File: tb/test_pio_cpu_if.sv
module test_pio_cpu_if;
  logic clk = 0, rst = 1;
  logic cs_n = 1, rd_n = 1, wr_n = 1;
  logic [1:0] addr = 0;
  logic [7:0] din = 0, pa_in = 0, pb_in = 0, pc_in = 0;
  logic [7:0] dout, pa_latch, pb_latch, pc_latch;
  logic dout_valid, pa_dir_in, pb_dir_in, pcl_dir_in, pcu_dir_in;
  logic [1:0] grp_a_mode;
  logic grp_b_mode, inte_a_out, inte_a_in, inte_b, flags_clr;

  int checks = 0, fails = 0, clr_seen = 0, clr_exp = 0;
  bit done = 0;

  // bench model
  logic [6:0] m_cfg;
  logic [7:0] m_pa, m_pb, m_pc;
  logic [2:0] m_inte;

  always #4 clk = ~clk;

  pio_cpu_if i_pio_cpu_if (.*);

  always @(posedge clk) if (!rst && flags_clr) clr_seen++;

  function automatic logic [1:0] f_amode(logic [6:0] c);
    case (c[6:5]) 2'b00: return 0; 2'b01: return 1; default: return 2; endcase
  endfunction

  function automatic logic [7:0] f_read(logic [1:0] a);
    logic [7:0] r;
    case (a)
      2'd0: r = c_sel(m_cfg[4], pa_in, m_pa);
      2'd1: r = c_sel(m_cfg[1], pb_in, m_pb);
      2'd2: begin
        for (int i = 0; i < 8; i++)
          r[i] = (i < 4 ? m_cfg[0] : m_cfg[3]) ? pc_in[i] : m_pc[i];
      end
      default: r = {1'b1, m_cfg};
    endcase
    return r;
  endfunction

  function automatic logic [7:0] c_sel(logic s, logic [7:0] a, logic [7:0] b);
    return s ? a : b;
  endfunction

  task automatic model_write(logic [1:0] a, logic [7:0] d);
    int n;
    logic hs_a, hs_b;
    hs_a = f_amode(m_cfg) != 0;
    hs_b = m_cfg[2];
    case (a)
      2'd0: m_pa = d;
      2'd1: m_pb = d;
      2'd2: for (int i = 0; i < 8; i++) begin
        if (i < 4 && !hs_b && !m_cfg[0]) m_pc[i] = d[i];
        if (i >= 4 && !hs_a && !m_cfg[3]) m_pc[i] = d[i];
      end
      default: if (d[7]) begin
        m_cfg = d[6:0]; m_pa = 0; m_pb = 0; m_pc = 0; m_inte = 0; clr_exp++;
      end else begin
        n = d[3:1];
        if (hs_a && n == 6)      m_inte[2] = d[0];
        else if (hs_a && n == 4) m_inte[1] = d[0];
        else if (hs_b && n == 2) m_inte[0] = d[0];
        else if (!(n < 4 ? m_cfg[0] : m_cfg[3])) m_pc[n] = d[0];
      end
    endcase
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d, bit sel = 1);
    @(negedge clk); addr = a; din = d; cs_n = !sel;
    @(negedge clk); wr_n = 0;
    repeat (4) @(negedge clk);
    wr_n = 1;
    repeat (3) @(negedge clk);
    cs_n = 1;
    if (sel) model_write(a, d);
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); addr = a; cs_n = 0; rd_n = 0;
    #1; d = dout; v = dout_valid;
    @(negedge clk); rd_n = 1; cs_n = 1;
  endtask

  task automatic check_all(string tag);
    logic [7:0] d;
    logic v;
    chk({tag, " R3 grp_a_mode"}, {6'd0, grp_a_mode}, {6'd0, f_amode(m_cfg)});
    chk({tag, " R3 dirs/b mode"}, {3'd0, grp_b_mode, pa_dir_in, pcu_dir_in, pb_dir_in, pcl_dir_in},
        {3'd0, m_cfg[2], m_cfg[4], m_cfg[3], m_cfg[1], m_cfg[0]});
    chk({tag, " R7 pa_latch"}, pa_latch, m_pa);
    chk({tag, " R7 pb_latch"}, pb_latch, m_pb);
    chk({tag, " R8 pc_latch"}, pc_latch, m_pc);
    chk({tag, " R10 inte"}, {5'd0, inte_a_out, inte_a_in, inte_b}, {5'd0, m_inte});
    chk({tag, " R6 flags_clr count"}, 8'(clr_seen), 8'(clr_exp));
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), d, v);
      chk({tag, " R1 read"}, d, f_read(2'(a)));
      chk({tag, " R1 dout_valid"}, {7'd0, v}, 8'd1);
      if (a == 3) chk({tag, " R4 bit7"}, {7'd0, d[7]}, 8'd1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic v;
    void'($urandom(32'd1234));
    m_cfg = 7'h1B; m_pa = 0; m_pb = 0; m_pc = 0; m_inte = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    // R5 reset state
    bus_read(2'd3, d, v);
    chk("R5 reset ctrl read", d, 8'h9B);
    pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h96;
    check_all("R5 reset");

    // R2 write without select is ignored
    bus_write(2'd0, 8'hFF, 0);
    bus_write(2'd3, 8'h80, 0);
    check_all("R2 no select");

    // R3 all outputs, mode 0
    bus_write(2'd3, 8'h80);
    bus_write(2'd0, 8'hA5);
    bus_write(2'd1, 8'h3C);
    bus_write(2'd2, 8'h7E);
    check_all("R7 outputs");
    // R8 set/reset with bits 6:4 set (ignored)
    bus_write(2'd3, 8'h71);  // bit 0 set? sel=0 val=1
    bus_write(2'd3, 8'h7C);  // sel=6 val=0
    check_all("R8 bsr");
    // R6 mode write clears
    bus_write(2'd3, 8'h89);  // upper and lower C inputs
    check_all("R6 mode clear");
    // R9 set/reset to input line
    bus_write(2'd3, 8'h0B);
    bus_write(2'd2, 8'hFF);
    check_all("R9 input line");
    // R10 handshake modes: A mode 2, B mode 1, C outputs
    bus_write(2'd3, 8'hC4);
    bus_write(2'd3, 8'h0D);  // sel6 -> inte_a_out
    bus_write(2'd3, 8'h09);  // sel4 -> inte_a_in
    bus_write(2'd3, 8'h05);  // sel2 -> inte_b
    bus_write(2'd3, 8'h0F);  // sel7 -> latch
    check_all("R10 inte");
    // R11 direct C write in handshake groups changes nothing, inte kept
    bus_write(2'd2, 8'hFF);
    check_all("R11 pc masked");
    bus_write(2'd3, 8'hA0);  // A mode 1, B mode 0
    bus_write(2'd2, 8'hFF);
    check_all("R11 lower only");

    for (int it = 0; it < 250; it++) begin
      logic [1:0] a;
      logic [7:0] dd;
      a = 2'($urandom_range(0, 3));
      dd = 8'($urandom);
      if (a == 2'd3 && dd[7] && $urandom_range(0, 2) != 0) dd[7] = 0;
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      bus_write(a, dd);
      check_all("random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule